// File: doc/BRIEF.md
# AUX Reply Status Error Classifier

This block sits beside an auxiliary-channel transaction engine and reduces the status word that engine raises when a transaction ends to a single 3-bit error code. Two decode schemes share the block. Native transfers use a short priority chain. I2C-over-AUX transfers have two cases. If the done flag is present, it decides the result on its own. If it is absent, the flags are examined in a fixed order in which each later match replaces the earlier result.

A status event is only acted on while the host marks a transaction as busy. Each serviced event produces exactly one completion pulse. The code is held in a register until the next serviced event. When the result is a physical-layer error, the block also asks for the engine's interrupt flags to be cleared. Flag positions inside the status word are parameters.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset `err_code` is 0, and `done_pulse` and `clr_req` are low. `err_code` uses this encoding: NONE=0, ADDR=1, TOUT=2, NACK=3, DEFER=4, NACK_DEFER=5, PHY=6. It never takes the value 7.
- R2: An event (`evt_valid` high at a clock edge) while `busy` is low is ignored. On the next cycle `done_pulse` and `clr_req` stay low and `err_code` is unchanged.
- R3: An event while `busy` is high is serviced. Servicing raises `done_pulse` for exactly one cycle, starting the cycle after the accepting edge, and the new `err_code` appears in that same cycle. Back-to-back serviced events give one pulse each.
- R4: The default status bit positions are: done=0, wrong-address=1, timeout=2, nack-or-defer=3, I2C nack=4, I2C defer=5, PHY=6. In native mode (`i2c_mode`=0), the done flag gives NONE unless a later override applies.
- R5: In native mode without done, wrong-address gives ADDR, and failing that, timeout gives TOUT. If the nack-or-defer flag is set, the result becomes NACK, even when done is also set. The I2C nack and I2C defer flags have no effect in native mode.
- R6: In native mode the PHY flag overrides every other result to PHY. It also raises `clr_req` for one cycle, alongside `done_pulse`.
- R7: In I2C mode with done set, the result is NACK if I2C nack or I2C defer is also set, and NONE otherwise. In this case the remaining flags, PHY included, are not consulted and `clr_req` stays low.
- R8: In I2C mode without done, these checks apply in order, each later match overriding the earlier result:
  - wrong-address gives ADDR, otherwise timeout gives TOUT;
  - nack-or-defer gives NACK_DEFER;
  - I2C nack gives NACK;
  - I2C defer gives DEFER;
  - PHY gives PHY and raises `clr_req`.
- R9: A serviced event whose flags match no rule for its mode still pulses `done_pulse`, and `err_code` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | A status word is presented this cycle |
| busy | input | 1 | A transaction is outstanding; qualifies `evt_valid` |
| i2c_mode | input | 1 | 1 selects the I2C-over-AUX decode, 0 selects native |
| status | input | STATUS_W | Captured interrupt status word |
| err_code | output | 3 | Registered error code |
| done_pulse | output | 1 | One-cycle completion strobe per serviced event |
| clr_req | output | 1 | One-cycle request to clear the engine's interrupt flags |

## Verification
The checker watches four things on every cycle:
- the idle-event rule;
- the one-cycle link from a serviced event to its completion strobe;
- that a clear request only comes with a PHY code and a strobe;
- the native-done and I2C-done outcomes.

The ordered override chain of I2C mode without done, the native precedence between address, timeout and nack-or-defer, and the hold of the old code on an unmatched event depend on flag combinations. Only the bench's directed scenarios cover those, since each needs a chosen flag pattern and a known previous code.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;

   localparam int CODE_W = 3;
   localparam int FLAG_N = 7;

   typedef enum logic [CODE_W-1:0] {
      ERR_NONE     = 3'd0,
      ERR_ADDR     = 3'd1,
      ERR_TOUT     = 3'd2,
      ERR_NACK     = 3'd3,
      ERR_DEFER    = 3'd4,
      ERR_NACK_DFR = 3'd5,
      ERR_PHY      = 3'd6
   } aux_err_e;

   // Decoded flag set; field order fixes the packed bit order (done is MSB).
   typedef struct packed {
      logic done;
      logic bad_addr;
      logic tmo;
      logic nak_dfr;
      logic i2c_nak;
      logic i2c_dfr;
      logic phy;
   } aux_flags_t;

   // Result of one decoder.
   typedef struct packed {
      logic     hit;
      aux_err_e code;
      logic     clr;
   } aux_dec_t;

endpackage

// File: rtl/aux_cls_flag_extract.sv
module aux_cls_flag_extract
   import aux_cls_pkg::*;
#(
   parameter int STATUS_W = 16,
   parameter int P_DONE   = 0,
   parameter int P_ADDR   = 1,
   parameter int P_TOUT   = 2,
   parameter int P_NKDF   = 3,
   parameter int P_INAK   = 4,
   parameter int P_IDFR   = 5,
   parameter int P_PHY    = 6
) (
   input  logic [STATUS_W-1:0] status,
   output aux_flags_t          flags
);

   localparam int POS [FLAG_N] = '{P_DONE, P_ADDR, P_TOUT, P_NKDF,
                                   P_INAK, P_IDFR, P_PHY};

   if (STATUS_W < FLAG_N) begin : g_bad_width
      $error("aux_cls_flag_extract: STATUS_W too small for the flag set");
   end

   logic [FLAG_N-1:0] bits;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_pick
      if (POS[i] < 0 || POS[i] >= STATUS_W) begin : g_range
         $error("aux_cls_flag_extract: flag position out of range");
      end
      for (genvar j = i + 1; j < FLAG_N; j++) begin : g_uniq
         if (POS[i] == POS[j]) begin : g_dup
            $error("aux_cls_flag_extract: two flags share a bit position");
         end
      end
      assign bits[FLAG_N-1-i] = status[POS[i]];
   end

   assign flags = aux_flags_t'(bits);

endmodule

// File: rtl/aux_cls_native_dec.sv
module aux_cls_native_dec
   import aux_cls_pkg::*;
(
   input  aux_flags_t flags,
   output aux_dec_t   dec
);

   always_comb begin
      dec.hit  = 1'b0;
      dec.code = ERR_NONE;
      dec.clr  = 1'b0;
      if (flags.done) begin
         dec.hit  = 1'b1;
         dec.code = ERR_NONE;
      end else if (flags.bad_addr) begin
         dec.hit  = 1'b1;
         dec.code = ERR_ADDR;
      end else if (flags.tmo) begin
         dec.hit  = 1'b1;
         dec.code = ERR_TOUT;
      end
      if (flags.nak_dfr) begin
         dec.hit  = 1'b1;
         dec.code = ERR_NACK;
      end
      if (flags.phy) begin
         dec.hit  = 1'b1;
         dec.code = ERR_PHY;
         dec.clr  = 1'b1;
      end
   end

endmodule

// File: rtl/aux_cls_i2c_dec.sv
module aux_cls_i2c_dec
   import aux_cls_pkg::*;
(
   input  aux_flags_t flags,
   output aux_dec_t   dec
);

   always_comb begin
      dec.hit  = 1'b0;
      dec.code = ERR_NONE;
      dec.clr  = 1'b0;
      if (flags.done) begin
         dec.hit  = 1'b1;
         dec.code = (flags.i2c_nak || flags.i2c_dfr) ? ERR_NACK : ERR_NONE;
      end else begin
         if (flags.bad_addr) begin
            dec.hit  = 1'b1;
            dec.code = ERR_ADDR;
         end else if (flags.tmo) begin
            dec.hit  = 1'b1;
            dec.code = ERR_TOUT;
         end
         if (flags.nak_dfr) begin
            dec.hit  = 1'b1;
            dec.code = ERR_NACK_DFR;
         end
         if (flags.i2c_nak) begin
            dec.hit  = 1'b1;
            dec.code = ERR_NACK;
         end
         if (flags.i2c_dfr) begin
            dec.hit  = 1'b1;
            dec.code = ERR_DEFER;
         end
         if (flags.phy) begin
            dec.hit  = 1'b1;
            dec.code = ERR_PHY;
            dec.clr  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/aux_cls_result_reg.sv
module aux_cls_result_reg
   import aux_cls_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     svc,
   input  aux_dec_t dec,
   output aux_err_e code_q,
   output logic     pulse_q,
   output logic     clr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= ERR_NONE;
         pulse_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         pulse_q <= svc;
         clr_q   <= svc && dec.clr;
         if (svc && dec.hit) begin
            code_q <= dec.code;
         end
      end
   end

endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
   import aux_cls_pkg::*;
#(
   parameter int STATUS_W = 16,
   parameter int P_DONE   = 0,
   parameter int P_ADDR   = 1,
   parameter int P_TOUT   = 2,
   parameter int P_NKDF   = 3,
   parameter int P_INAK   = 4,
   parameter int P_IDFR   = 5,
   parameter int P_PHY    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic                busy,
   input  logic                i2c_mode,
   input  logic [STATUS_W-1:0] status,
   output logic [2:0]          err_code,
   output logic                done_pulse,
   output logic                clr_req
);

   aux_flags_t flags;
   aux_dec_t   dec_nat;
   aux_dec_t   dec_i2c;
   aux_dec_t   dec_sel;
   aux_err_e   code_q;
   logic       svc;

   aux_cls_flag_extract #(
      .STATUS_W (STATUS_W),
      .P_DONE   (P_DONE),
      .P_ADDR   (P_ADDR),
      .P_TOUT   (P_TOUT),
      .P_NKDF   (P_NKDF),
      .P_INAK   (P_INAK),
      .P_IDFR   (P_IDFR),
      .P_PHY    (P_PHY)
   ) u_extract (
      .status (status),
      .flags  (flags)
   );

   aux_cls_native_dec u_nat (
      .flags (flags),
      .dec   (dec_nat)
   );

   aux_cls_i2c_dec u_i2c (
      .flags (flags),
      .dec   (dec_i2c)
   );

   assign dec_sel = i2c_mode ? dec_i2c : dec_nat;
   assign svc     = evt_valid && busy;

   aux_cls_result_reg u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .svc     (svc),
      .dec     (dec_sel),
      .code_q  (code_q),
      .pulse_q (done_pulse),
      .clr_q   (clr_req)
   );

   assign err_code = code_q;

endmodule

// File: rtl/aux_reply_classifier_chk.sv
module aux_reply_classifier_chk #(
   parameter int STATUS_W = 16,
   parameter int P_DONE   = 0,
   parameter int P_ADDR   = 1,
   parameter int P_TOUT   = 2,
   parameter int P_NKDF   = 3,
   parameter int P_INAK   = 4,
   parameter int P_IDFR   = 5,
   parameter int P_PHY    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic                busy,
   input logic                i2c_mode,
   input logic [STATUS_W-1:0] status,
   input logic [2:0]          err_code,
   input logic                done_pulse,
   input logic                clr_req
);

   logic serviced;
   assign serviced = evt_valid && busy;

   // R1: the unused encoding 7 is never produced
   a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      err_code != 3'd7);

   // R2: an unqualified event leaves every output untouched
   a_r2_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !serviced |=> (!done_pulse && !clr_req && $stable(err_code)));

   // R3: a serviced event yields the strobe on the next cycle
   a_r3_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      serviced |=> done_pulse);

   // R3: no strobe without a serviced event one cycle earlier
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> $past(serviced));

   // R6 / R8: a clear request only comes with a PHY code and a strobe
   a_r6_clr_with_phy: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |-> (done_pulse && err_code == 3'd6));

   // R4: native done with no override flag gives NONE
   a_r4_native_done: assert property (@(posedge clk) disable iff (!rst_n)
      (serviced && !i2c_mode && status[P_DONE] && !status[P_NKDF] && !status[P_PHY])
      |=> (err_code == 3'd0));

   // R7: I2C done decides alone and never requests a clear
   a_r7_i2c_done: assert property (@(posedge clk) disable iff (!rst_n)
      (serviced && i2c_mode && status[P_DONE])
      |=> (!clr_req && err_code == (($past(status[P_INAK]) || $past(status[P_IDFR])) ? 3'd3 : 3'd0)));

endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(
   .STATUS_W (STATUS_W),
   .P_DONE   (P_DONE),
   .P_ADDR   (P_ADDR),
   .P_TOUT   (P_TOUT),
   .P_NKDF   (P_NKDF),
   .P_INAK   (P_INAK),
   .P_IDFR   (P_IDFR),
   .P_PHY    (P_PHY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_valid  (evt_valid),
   .busy       (busy),
   .i2c_mode   (i2c_mode),
   .status     (status),
   .err_code   (err_code),
   .done_pulse (done_pulse),
   .clr_req    (clr_req)
);

// File: tb/aux_reply_classifier_bench.sv
module aux_reply_classifier_bench;

   localparam int SW = 16;
   // bit positions per R4
   localparam logic [SW-1:0] F_DONE = 16'h0001;
   localparam logic [SW-1:0] F_ADDR = 16'h0002;
   localparam logic [SW-1:0] F_TOUT = 16'h0004;
   localparam logic [SW-1:0] F_NKDF = 16'h0008;
   localparam logic [SW-1:0] F_INAK = 16'h0010;
   localparam logic [SW-1:0] F_IDFR = 16'h0020;
   localparam logic [SW-1:0] F_PHY  = 16'h0040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0;
   logic          busy = 1'b0;
   logic          i2c_mode = 1'b0;
   logic [SW-1:0] status = '0;
   logic [2:0]    err_code;
   logic          done_pulse;
   logic          clr_req;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   aux_reply_classifier #(.STATUS_W(SW)) u_aux_reply_classifier (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_valid  (evt_valid),
      .busy       (busy),
      .i2c_mode   (i2c_mode),
      .status     (status),
      .err_code   (err_code),
      .done_pulse (done_pulse),
      .clr_req    (clr_req)
   );

   task automatic chk(input string tag, input logic [2:0] e_code,
                      input logic e_pulse, input logic e_clr);
      n_chk++;
      if (err_code !== e_code || done_pulse !== e_pulse || clr_req !== e_clr) begin
         n_bad++;
         $display("FAIL %s: code/pulse/clr = %0d/%0b/%0b expected %0d/%0b/%0b",
                  tag, err_code, done_pulse, clr_req, e_code, e_pulse, e_clr);
      end
   endtask

   // Presents one event at a falling edge; the result is sampled at the next falling edge.
   task automatic event1(input logic mode, input logic bsy, input logic [SW-1:0] st,
                         input string tag, input logic [2:0] e_code, input logic e_pulse,
                         input logic e_clr);
      @(negedge clk);
      i2c_mode  = mode;
      busy      = bsy;
      status    = st;
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      status    = '0;
      chk(tag, e_code, e_pulse, e_clr);
   endtask

   task automatic t_reset;
      chk("R1 reset", 3'd0, 1'b0, 1'b0);
   endtask

   task automatic t_native;
      event1(0, 1, F_ADDR,          "R5 native addr",       3'd1, 1, 0);
      @(negedge clk);
      chk("R3 pulse one cycle", 3'd1, 0, 0);
      event1(0, 1, F_DONE,          "R4 native done",       3'd0, 1, 0);
      event1(0, 1, F_ADDR | F_TOUT, "R5 addr over tout",    3'd1, 1, 0);
      event1(0, 1, F_TOUT,          "R5 native tout",       3'd2, 1, 0);
      event1(0, 1, F_ADDR | F_NKDF, "R5 nkdf overrides",    3'd3, 1, 0);
      event1(0, 1, F_DONE | F_NKDF, "R5 nkdf over done",    3'd3, 1, 0);
      event1(0, 1, F_DONE,          "R4 native done again", 3'd0, 1, 0);
      event1(0, 1, F_INAK | F_IDFR, "R5 i2c flags ignored", 3'd0, 1, 0);
   endtask

   task automatic t_native_phy;
      event1(0, 1, F_DONE | F_PHY,  "R6 native phy",        3'd6, 1, 1);
   endtask

   task automatic t_idle;
      event1(0, 0, F_ADDR,          "R2 idle native",       3'd6, 0, 0);
      event1(1, 0, F_DONE,          "R2 idle i2c",          3'd6, 0, 0);
   endtask

   task automatic t_i2c_done;
      event1(1, 1, F_DONE | F_INAK, "R7 done+nak",          3'd3, 1, 0);
      event1(1, 1, F_DONE,          "R7 done alone",        3'd0, 1, 0);
      event1(1, 1, F_DONE | F_IDFR, "R7 done+defer",        3'd3, 1, 0);
      event1(1, 1, F_DONE | F_PHY,  "R7 done hides phy",    3'd0, 1, 0);
   endtask

   task automatic t_i2c_chain;
      event1(1, 1, F_ADDR | F_TOUT, "R8 addr",              3'd1, 1, 0);
      event1(1, 1, F_TOUT,          "R8 tout",              3'd2, 1, 0);
      event1(1, 1, F_ADDR | F_NKDF, "R8 nack_defer",        3'd5, 1, 0);
      event1(1, 1, F_NKDF | F_INAK, "R8 i2c nak",           3'd3, 1, 0);
      event1(1, 1, F_INAK | F_IDFR, "R8 i2c defer",         3'd4, 1, 0);
      event1(1, 1, F_TOUT | F_IDFR | F_PHY, "R8 phy last",  3'd6, 1, 1);
   endtask

   task automatic t_hold;
      event1(1, 1, '0,              "R9 i2c no match hold",  3'd6, 1, 0);
      event1(0, 1, F_TOUT,          "R9 setup",              3'd2, 1, 0);
      event1(0, 1, 16'h0100,        "R9 native no match",    3'd2, 1, 0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      i2c_mode = 1'b0;
      busy = 1'b1;
      status = F_ADDR;
      evt_valid = 1'b1;
      @(negedge clk);
      status = F_NKDF;
      chk("R3 back-to-back first", 3'd1, 1, 0);
      @(negedge clk);
      evt_valid = 1'b0;
      status = '0;
      chk("R3 back-to-back second", 3'd3, 1, 0);
      @(negedge clk);
      chk("R3 strobe ends", 3'd3, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_native();
      t_native_phy();
      t_idle();
      t_i2c_done();
      t_i2c_chain();
      t_hold();
      t_back_to_back();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule